// File: doc/BRIEF.md
# Dual-Port Byte Memory with Cross-Port Mailbox Interrupts

The block is a shared byte memory with two independent synchronous ports, called left and right. Both ports address the same array, so either side can write a location and the other can read it back. Each port has its own chip select, write enable, read enable, address, write data and registered read data. Reads return data one cycle after the request.

The two highest addresses are mailbox locations. When a port writes the mailbox that belongs to the opposite port, the byte is stored like any other byte and the opposite port's active-low interrupt output goes low. The interrupt stays low until the receiving port reads its own mailbox. That read returns the message byte and clears the interrupt in the same access, so neither processor needs to poll a status byte. With the default 10-bit address, the left port's mailbox is at 0x3FE and the right port's mailbox is at 0x3FF.

When both ports write the same address in the same cycle, the left port's byte is stored. A read that coincides with a write to the same address returns the byte that was there before the write.

Top module: `dpm_mbox`

## Requirements
- R1: While reset is high and on the first cycle after it, `l_irq_n` and `r_irq_n` are 1 and `l_rdata` and `r_rdata` are 0. Memory contents are undefined after reset.
- R2: A read (`cs`=1, `re`=1) on a port presents the addressed byte on that port's `rdata` after the next rising edge. `rdata` keeps its value in cycles with no read on that port.
- R3: A write (`cs`=1, `we`=1) from either port stores `wdata` at `addr`, and both ports read back the same byte from that address.
- R4: A right-port write to address DEPTH-2 (0x3FE) stores the byte and drives `l_irq_n` to 0 after that clock edge.
- R5: A left-port read of address DEPTH-2 (0x3FE) returns the stored byte and drives `l_irq_n` to 1 after the same edge.
- R6: A left-port write to address DEPTH-1 (0x3FF) stores the byte and drives `r_irq_n` to 0 after that clock edge.
- R7: A right-port read of address DEPTH-1 (0x3FF) returns the stored byte and drives `r_irq_n` to 1 after the same edge.
- R8: An asserted interrupt stays at 0 through any number of cycles and any other accesses until its clearing read.
- R9: A port's write to its own mailbox does not change its own interrupt, and a port's read of the other port's mailbox does not change the other port's interrupt.
- R10: When the setting write and the clearing read of the same interrupt happen in the same cycle, the interrupt ends at 0.
- R11: When both ports write the same address in the same cycle, the left port's byte is the one stored.
- R12: A read in the same cycle as a write to the same address, from either port, returns the byte stored before that write.
- R13: With `cs`=0 a port's `we` and `re` have no effect: memory, `rdata` and both interrupts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left port write enable |
| l_re | input | 1 | Left port read enable |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write byte |
| l_rdata | output | DATA_W | Left port read byte, registered |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right port write enable |
| r_re | input | 1 | Right port read enable |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write byte |
| r_rdata | output | DATA_W | Right port read byte, registered |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with its default widths, 10 address bits and 8 data bits. This places the mailboxes at 0x3FE and 0x3FF and makes the full 1024-byte range reachable, so the bench covers the lowest address, the last ordinary address just below the mailboxes, and both mailboxes. A behavioural model tracks every byte and both interrupt flags. Using it, the bench drives same-cycle collisions: write against write, write against read, and set against clear on a single flag. These are the cases where the ordering rules decide the result.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // Decoded activity of one port in one cycle
    typedef struct packed {
        logic wr;        // selected write
        logic rd;        // selected read
        logic hit_own;   // address is this side's inbox
        logic hit_peer;  // address is the opposite side's inbox
    } port_act_t;

    // Inbox address of a side: the left side owns DEPTH-2, the right DEPTH-1
    function automatic int unsigned inbox_index(input side_e s, input int unsigned depth);
        return (s == SIDE_L) ? depth - 2 : depth - 1;
    endfunction

    function automatic side_e other_side(input side_e s);
        return (s == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter side_e       SIDE   = SIDE_L
) (
    input  logic              cs,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    output port_act_t         act
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] OWN_BOX  = ADDR_W'(inbox_index(SIDE, DEPTH));
    localparam logic [ADDR_W-1:0] PEER_BOX = ADDR_W'(inbox_index(other_side(SIDE), DEPTH));

    always_comb begin
        act.wr       = cs && we;
        act.rd       = cs && re;
        act.hit_own  = (addr == OWN_BOX);
        act.hit_peer = (addr == PEER_BOX);
    end
endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port a is applied last, so it wins a same-address write
    always_ff @(posedge clk) begin
        if (b_wr) mem[b_addr] <= b_wdata;
        if (a_wr) mem[a_addr] <= a_wdata;
    end

    // Reads sample the array before this edge's writes land
    always_ff @(posedge clk) begin
        if (rst) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= mem[a_addr];
            if (b_rd) b_rdata <= mem[b_addr];
        end
    end
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    // Set has priority so a message arriving during a clearing read survives
    always_ff @(posedge clk) begin
        if (rst)      irq_n <= 1'b1;
        else if (set) irq_n <= 1'b0;
        else if (clr) irq_n <= 1'b1;
    end
endmodule

// File: rtl/dpm_mbox.sv
module dpm_mbox
    import dpm_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int unsigned NSIDE = 2;

    logic              cs_v   [NSIDE];
    logic              we_v   [NSIDE];
    logic              re_v   [NSIDE];
    logic [ADDR_W-1:0] addr_v [NSIDE];
    port_act_t         act    [NSIDE];
    logic              irq_v  [NSIDE];

    assign cs_v[0]   = l_cs;
    assign we_v[0]   = l_we;
    assign re_v[0]   = l_re;
    assign addr_v[0] = l_addr;
    assign cs_v[1]   = r_cs;
    assign we_v[1]   = r_we;
    assign re_v[1]   = r_re;
    assign addr_v[1] = r_addr;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam side_e ME = (s == 0) ? SIDE_L : SIDE_R;
        localparam int    PEER = 1 - s;

        dpm_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (ME)
        ) u_dec (
            .cs   (cs_v[s]),
            .we   (we_v[s]),
            .re   (re_v[s]),
            .addr (addr_v[s]),
            .act  (act[s])
        );

        dpm_irq_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (act[PEER].wr && act[PEER].hit_peer),
            .clr   (act[s].rd && act[s].hit_own),
            .irq_n (irq_v[s])
        );
    end

    assign l_irq_n = irq_v[0];
    assign r_irq_n = irq_v[1];

    dpm_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .a_wr    (act[0].wr),
        .a_rd    (act[0].rd),
        .a_addr  (l_addr),
        .a_wdata (l_wdata),
        .a_rdata (l_rdata),
        .b_wr    (act[1].wr),
        .b_rd    (act[1].rd),
        .b_addr  (r_addr),
        .b_wdata (r_wdata),
        .b_rdata (r_rdata)
    );
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs,
    input logic              l_we,
    input logic              l_re,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_cs,
    input logic              r_we,
    input logic              r_re,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'(DEPTH - 1);

    logic set_l, clr_l, set_r, clr_r;
    assign set_l = r_cs && r_we && (r_addr == L_BOX);
    assign clr_l = l_cs && l_re && (l_addr == L_BOX);
    assign set_r = l_cs && l_we && (l_addr == R_BOX);
    assign clr_r = r_cs && r_re && (r_addr == R_BOX);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));

    p_rdata_hold_l_r2: assert property (@(posedge clk) disable iff (rst)
        !(l_cs && l_re) |=> $stable(l_rdata));
    p_rdata_hold_r_r2: assert property (@(posedge clk) disable iff (rst)
        !(r_cs && r_re) |=> $stable(r_rdata));

    p_left_set_r4: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !l_irq_n);
    p_left_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !set_l) |=> l_irq_n);
    p_right_set_r6: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !r_irq_n);
    p_right_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !set_r) |=> r_irq_n);

    // R8 and R9: only the two named events move a flag
    p_left_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!set_l && !clr_l) |=> $stable(l_irq_n));
    p_right_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!set_r && !clr_r) |=> $stable(r_irq_n));
endmodule

bind dpm_mbox dpm_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/dpm_mbox_test.sv
`timescale 1ns/1ps
module dpm_mbox_test;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LBOX = 10'h3FE;
    localparam logic [AW-1:0] RBOX = 10'h3FF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_cs = 0, l_we = 0, l_re = 0, r_cs = 0, r_we = 0, r_re = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    always #2.5 clk = ~clk;

    dpm_mbox #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .l_cs(l_cs), .l_we(l_we), .l_re(l_re), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs(r_cs), .r_we(r_we), .r_re(r_re), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit [DW-1:0] m_mem [DEPTH];
    bit          m_known [DEPTH];
    bit [DW-1:0] m_l = '0, m_r = '0;
    bit          m_l_ok = 1'b1, m_r_ok = 1'b1;
    bit          m_lirq = 1'b1, m_rirq = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            m_l = '0; m_r = '0; m_l_ok = 1; m_r_ok = 1;
            m_lirq = 1; m_rirq = 1;
        end else begin
            bit lw, lr, rw, rr;
            lw = l_cs && l_we; lr = l_cs && l_re;
            rw = r_cs && r_we; rr = r_cs && r_re;
            if (lr) begin m_l = m_mem[l_addr]; m_l_ok = m_known[l_addr]; end
            if (rr) begin m_r = m_mem[r_addr]; m_r_ok = m_known[r_addr]; end
            if (rw && r_addr == LBOX) m_lirq = 0;
            else if (lr && l_addr == LBOX) m_lirq = 1;
            if (lw && l_addr == RBOX) m_rirq = 0;
            else if (rr && r_addr == RBOX) m_rirq = 1;
            if (rw) begin m_mem[r_addr] = r_wdata; m_known[r_addr] = 1; end
            if (lw) begin m_mem[l_addr] = l_wdata; m_known[l_addr] = 1; end
        end
    end

    // Compare every clock, one time unit after the edge
    always @(posedge clk) begin
        #1;
        check({cur_req, " l_irq_n"}, 32'(l_irq_n), 32'(m_lirq));
        check({cur_req, " r_irq_n"}, 32'(r_irq_n), 32'(m_rirq));
        if (m_l_ok) check({cur_req, " l_rdata"}, 32'(l_rdata), 32'(m_l));
        if (m_r_ok) check({cur_req, " r_rdata"}, 32'(r_rdata), 32'(m_r));
    end

    task automatic cyc(input string tag,
                       input logic lc, input logic lw, input logic lr,
                       input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic rc, input logic rw, input logic rr,
                       input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        @(negedge clk);
        cur_req = tag;
        l_cs = lc; l_we = lw; l_re = lr; l_addr = la; l_wdata = ld;
        r_cs = rc; r_we = rw; r_re = rr; r_addr = ra; r_wdata = rd;
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 l_irq_n after reset", 32'(l_irq_n), 1);
        check("R1 r_irq_n after reset", 32'(r_irq_n), 1);
        check("R1 l_rdata after reset", 32'(l_rdata), 0);
        check("R1 r_rdata after reset", 32'(r_rdata), 0);

        // R3: writes from each side, read back from both
        cyc("R3", 1, 1, 0, 10'h005, 8'hA5, 1, 1, 0, 10'h200, 8'h3C);
        cyc("R3", 1, 1, 0, 10'h000, 8'h11, 1, 1, 0, 10'h3FD, 8'hEE);
        cyc("R3", 1, 0, 1, 10'h200, 8'h00, 1, 0, 1, 10'h005, 8'h00);
        cyc("R3", 1, 0, 1, 10'h3FD, 8'h00, 1, 0, 1, 10'h000, 8'h00);
        // R2: outputs hold through idle cycles
        idle("R2"); idle("R2"); idle("R2");
        @(negedge clk);
        check("R2 l_rdata held", 32'(l_rdata), 32'h0EE);
        check("R2 r_rdata held", 32'(r_rdata), 32'h011);

        // R4: right posts to left inbox
        cyc("R4", 0, 0, 0, '0, '0, 1, 1, 0, LBOX, 8'h81);
        @(negedge clk);
        check("R4 l_irq_n low", 32'(l_irq_n), 0);
        // R8: other traffic leaves it low
        cyc("R8", 1, 0, 1, 10'h005, 8'h00, 1, 0, 1, 10'h200, 8'h00);
        idle("R8"); idle("R8");
        // R9: right reads left inbox, left writes nothing relevant
        cyc("R9", 0, 0, 0, '0, '0, 1, 0, 1, LBOX, 8'h00);
        idle("R9");
        @(negedge clk);
        check("R9 l_irq_n still low", 32'(l_irq_n), 0);
        // R5: left clearing read
        cyc("R5", 1, 0, 1, LBOX, 8'h00, 0, 0, 0, '0, '0);
        idle("R5");
        check("R5 l_rdata message", 32'(l_rdata), 32'h081);
        check("R5 l_irq_n cleared", 32'(l_irq_n), 1);

        // R6 / R7 mirror
        cyc("R6", 1, 1, 0, RBOX, 8'h5A, 0, 0, 0, '0, '0);
        idle("R6");
        check("R6 r_irq_n low", 32'(r_irq_n), 0);
        cyc("R9", 1, 0, 1, RBOX, 8'h00, 0, 0, 0, '0, '0);
        idle("R9");
        check("R9 r_irq_n not cleared by left", 32'(r_irq_n), 0);
        cyc("R7", 0, 0, 0, '0, '0, 1, 0, 1, RBOX, 8'h00);
        idle("R7");
        check("R7 r_rdata message", 32'(r_rdata), 32'h05A);
        check("R7 r_irq_n cleared", 32'(r_irq_n), 1);

        // R9: own-inbox writes do not raise own interrupt
        cyc("R9", 1, 1, 0, LBOX, 8'h22, 1, 1, 0, RBOX, 8'h33);
        idle("R9");
        check("R9 l_irq_n own write", 32'(l_irq_n), 1);
        check("R9 r_irq_n own write", 32'(r_irq_n), 1);

        // R10: set and clear of left flag together
        cyc("R10", 1, 0, 1, LBOX, 8'h00, 1, 1, 0, LBOX, 8'h99);
        idle("R10");
        check("R10 l_irq_n set wins", 32'(l_irq_n), 0);
        check("R10 l_rdata old byte", 32'(l_rdata), 32'h022);
        cyc("R10", 1, 0, 1, LBOX, 8'h00, 0, 0, 0, '0, '0);
        idle("R10");
        check("R10 later clear", 32'(l_irq_n), 1);
        // same for right flag
        cyc("R10", 1, 1, 0, RBOX, 8'h77, 1, 0, 1, RBOX, 8'h00);
        idle("R10");
        check("R10 r_irq_n set wins", 32'(r_irq_n), 0);
        cyc("R7", 0, 0, 0, '0, '0, 1, 0, 1, RBOX, 8'h00);
        idle("R7");

        // R11: write-write collision
        cyc("R11", 1, 1, 0, 10'h100, 8'hC3, 1, 1, 0, 10'h100, 8'h3C);
        cyc("R11", 1, 0, 1, 10'h100, 8'h00, 1, 0, 1, 10'h100, 8'h00);
        idle("R11");
        check("R11 left wins (l)", 32'(l_rdata), 32'h0C3);
        check("R11 left wins (r)", 32'(r_rdata), 32'h0C3);

        // R12: read against write, both directions, and same-port
        cyc("R12", 1, 1, 0, 10'h050, 8'h01, 0, 0, 0, '0, '0);
        cyc("R12", 1, 1, 0, 10'h050, 8'h02, 1, 0, 1, 10'h050, 8'h00);
        cyc("R12", 1, 0, 1, 10'h050, 8'h00, 1, 1, 0, 10'h050, 8'h03);
        idle("R12");
        check("R12 r_rdata old", 32'(r_rdata), 32'h001);
        check("R12 l_rdata old", 32'(l_rdata), 32'h002);
        cyc("R12", 1, 1, 1, 10'h050, 8'h04, 0, 0, 0, '0, '0);
        idle("R12");
        check("R12 same-port old", 32'(l_rdata), 32'h003);

        // R13: deselected strobes
        cyc("R13", 0, 1, 1, RBOX, 8'hF0, 0, 1, 1, LBOX, 8'hF1);
        idle("R13");
        check("R13 l_irq_n", 32'(l_irq_n), 1);
        check("R13 r_irq_n", 32'(r_irq_n), 1);
        check("R13 l_rdata stable", 32'(l_rdata), 32'h003);
        cyc("R13", 1, 0, 1, RBOX, 8'h00, 1, 0, 1, LBOX, 8'h00);
        idle("R13");
        check("R13 mbox R unchanged", 32'(l_rdata), 32'h077);
        check("R13 mbox L unchanged", 32'(r_rdata), 32'h099);

        idle("R2"); idle("R2");
        finish_run();
    end
endmodule